// File: doc/BRIEF.md
# Offset Compare Timer Channel

This block is one deadline timer channel fed by a shared, free-running 64-bit system count. The channel keeps a programmable 64-bit offset and subtracts it from the system count to form its own count. That channel count is compared against a 64-bit deadline. When the count has reached or passed the deadline, a status flag is set. An interrupt line is asserted if the channel is also enabled and not masked.

Software reaches the channel through a 32-bit register port. A 3-bit index selects the register, writes take effect on the clock edge, and reads are combinational. The deadline can be written as an absolute value, one 32-bit half at a time. It can also be written as a signed 32-bit distance from the current channel count. The system count itself comes from outside the block and is never written here. All pins are plain control and data pins, so there is no back-pressure.

Top module: `oct_timer_channel`

## Requirements
- R1: The channel count equals the system count minus the offset, modulo 2^64. It reads back at index 6 (low 32 bits) and index 7 (high 32 bits).
- R2: The condition holds when the channel count is greater than or equal to the deadline, compared as unsigned numbers. The status flag reads at control bit 2 one cycle after the condition changes. It follows the condition whether or not the channel is enabled.
- R3: A write to index 4 sets the deadline to the channel count at that edge plus the written value sign-extended to 64 bits.
- R4: The interrupt output is a level signal. It is 1 exactly when, one cycle earlier, enable was 1, mask was 0 and the condition held. It falls as soon as any one of the three stops holding.
- R5: A write to index 5 (control) sets only enable (bit 0) and mask (bit 1). The status bit cannot be written, and bits 31..3 read as zero. A control write leaves the deadline and the offset unchanged.
- R6: Index 0 and index 1 write and read the low and high 32 bits of the deadline. Each write replaces only its own half, and the condition is evaluated again against the new deadline.
- R7: Index 2 and index 3 write and read the low and high 32 bits of the offset. Each write replaces only its own half, and the condition is evaluated again against the new channel count. An offset write leaves the deadline unchanged.
- R8: A read of index 4 returns the deadline minus the channel count, truncated to 32 bits. The value is negative once the deadline has passed.
- R9: While reset is held, the interrupt is 0 and the control register reads 0. Reset clears the deadline, the offset, enable and mask.
- R10: Writes to index 6 and index 7 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Shared free-running system count |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_idx |
| irq | output | 1 | Level interrupt |

## Verification
The deadline is first programmed as an absolute value and the system count is stepped across it. This separates a greater-or-equal test from a strict greater-than test, and it shows the deadline's high half taking part in the comparison. Relative writes use positive values, small negative values and negative values that wrap through zero. These separate sign extension from zero extension and signed comparison from unsigned comparison. Every combination of enable and mask is tried while the condition holds, which shows that the status flag stays independent of the gating. Offset writes, control writes that carry junk in the upper bits, and writes to the read-only count indices show which registers each write may touch.

// File: rtl/oct_pkg.sv
package oct_pkg;
  typedef enum logic [2:0] {
    IDX_DL_LO  = 3'd0,
    IDX_DL_HI  = 3'd1,
    IDX_OFS_LO = 3'd2,
    IDX_OFS_HI = 3'd3,
    IDX_REL    = 3'd4,
    IDX_CTRL   = 3'd5,
    IDX_CNT_LO = 3'd6,
    IDX_CNT_HI = 3'd7
  } reg_idx_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MASK_BIT = 1;
  localparam int CTRL_STAT_BIT = 2;

  typedef struct packed {
    logic mask;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/oct_count_view.sv
module oct_count_view #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] sys_count,
  input  logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] chan_count
);
  always_comb chan_count = sys_count - offset;
endmodule

// File: rtl/oct_regfile.sv
module oct_regfile
  import oct_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  chan_count,
  output logic [CNT_W-1:0]  deadline,
  output logic [CNT_W-1:0]  offset,
  output ctrl_t             ctrl
);
  localparam int HALF = CNT_W / 2;
  localparam int EXT  = CNT_W - DATA_W;

  logic [CNT_W-1:0] rel_sext;
  always_comb rel_sext = {{EXT{wdata[DATA_W-1]}}, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deadline <= '0;
      offset   <= '0;
      ctrl     <= '0;
    end else if (wr_en) begin
      unique case (idx)
        IDX_DL_LO:  deadline[HALF-1:0]     <= wdata[HALF-1:0];
        IDX_DL_HI:  deadline[CNT_W-1:HALF] <= wdata[HALF-1:0];
        IDX_OFS_LO: offset[HALF-1:0]       <= wdata[HALF-1:0];
        IDX_OFS_HI: offset[CNT_W-1:HALF]   <= wdata[HALF-1:0];
        IDX_REL:    deadline               <= chan_count + rel_sext;
        IDX_CTRL: begin
          ctrl.en   <= wdata[CTRL_EN_BIT];
          ctrl.mask <= wdata[CTRL_MASK_BIT];
        end
        default: ;
      endcase
    end
  end

  // R5: a control write leaves deadline and offset alone
  assert_ctrl_write_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_CTRL) |=> ($stable(deadline) && $stable(offset)));

  // R7: an offset write leaves the deadline alone
  assert_offset_write_keeps_deadline_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDX_OFS_LO || idx == IDX_OFS_HI)) |=> $stable(deadline));

  // R10: writes to count indices change nothing
  assert_count_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDX_CNT_LO || idx == IDX_CNT_HI)) |=>
      ($stable(deadline) && $stable(offset) && $stable(ctrl)));
endmodule

// File: rtl/oct_cond_irq.sv
module oct_cond_irq
  import oct_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] chan_count,
  input  logic [CNT_W-1:0] deadline,
  input  ctrl_t            ctrl,
  output logic             status,
  output logic             irq
);
  logic cond;
  always_comb cond = (chan_count >= deadline);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= cond;
      irq    <= cond && ctrl.en && !ctrl.mask;
    end
  end

  // R4: interrupt only when previously enabled and unmasked
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(ctrl.en) && !$past(ctrl.mask)));

  // R4: interrupt never without status
  assert_irq_needs_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status);

  // R2: a rising status follows a count at or past the deadline
  assert_status_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(chan_count >= deadline));
endmodule

// File: rtl/oct_timer_channel.sv
module oct_timer_channel
  import oct_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int HALF = CNT_W / 2;

  reg_idx_e         idx;
  logic [CNT_W-1:0] chan_count;
  logic [CNT_W-1:0] deadline;
  logic [CNT_W-1:0] offset;
  logic [CNT_W-1:0] remaining;
  ctrl_t            ctrl;
  logic             status;

  always_comb idx = reg_idx_e'(reg_idx);

  oct_count_view #(.CNT_W(CNT_W)) u_view (
    .sys_count  (sys_count),
    .offset     (offset),
    .chan_count (chan_count)
  );

  oct_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .idx        (idx),
    .wdata      (reg_wdata),
    .chan_count (chan_count),
    .deadline   (deadline),
    .offset     (offset),
    .ctrl       (ctrl)
  );

  oct_cond_irq #(.CNT_W(CNT_W)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_count (chan_count),
    .deadline   (deadline),
    .ctrl       (ctrl),
    .status     (status),
    .irq        (irq)
  );

  always_comb remaining = deadline - chan_count;

  always_comb begin
    reg_rdata = '0;
    unique case (idx)
      IDX_DL_LO:  reg_rdata = deadline[HALF-1:0];
      IDX_DL_HI:  reg_rdata = deadline[CNT_W-1:HALF];
      IDX_OFS_LO: reg_rdata = offset[HALF-1:0];
      IDX_OFS_HI: reg_rdata = offset[CNT_W-1:HALF];
      IDX_REL:    reg_rdata = remaining[DATA_W-1:0];
      IDX_CTRL: begin
        reg_rdata[CTRL_EN_BIT]   = ctrl.en;
        reg_rdata[CTRL_MASK_BIT] = ctrl.mask;
        reg_rdata[CTRL_STAT_BIT] = status;
      end
      IDX_CNT_LO: reg_rdata = chan_count[HALF-1:0];
      IDX_CNT_HI: reg_rdata = chan_count[CNT_W-1:HALF];
      default: ;
    endcase
  end

  // R9: nothing pending right after reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !$past(rst_n) |-> (!irq && !status));
endmodule

// File: tb/tb_oct_timer_channel.sv
module tb_oct_timer_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_ofs, m_dl;
  logic        m_en, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  oct_timer_channel dut (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .reg_wr_en(reg_wr_en),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [63:0] m_cnt();
    return sys_count - m_ofs;
  endfunction

  function automatic logic m_cond();
    return m_cnt() >= m_dl;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] v);
    reg_idx = i;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_sys(logic [63:0] v);
    @(negedge clk);
    sys_count = v;
    step(2);
  endtask

  task automatic check_state(string tag);
    logic [31:0] v;
    rd(3'd5, v);
    check({tag, " ctrl"}, v, {29'b0, m_cond(), m_mask, m_en});
    check({tag, " irq"}, irq, m_cond() && m_en && !m_mask);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd5, v);
    check("R9 ctrl in reset", v, 0);
    check("R9 irq in reset", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    m_ofs = 0; m_dl = 0; m_en = 0; m_mask = 0;
    step(2);
    rd(3'd0, v); check("R9 deadline lo zero", v, 0);
    rd(3'd3, v); check("R9 offset hi zero", v, 0);
    check_state("R9 after reset");
  endtask

  task automatic t_view;
    logic [31:0] v;
    set_sys(64'h1_0000_0100);
    wr(3'd2, 32'h100); m_ofs[31:0] = 32'h100;
    wr(3'd3, 32'h1);   m_ofs[63:32] = 32'h1;
    rd(3'd6, v); check("R1 count lo", v, m_cnt()[31:0]);
    rd(3'd7, v); check("R1 count hi", v, m_cnt()[63:32]);
    rd(3'd2, v); check("R7 offset lo", v, 32'h100);
  endtask

  task automatic t_abs;
    logic [31:0] v;
    wr(3'd0, 32'h10); m_dl[31:0] = 32'h10;
    step(2); check_state("R6 below deadline");
    wr(3'd5, 32'h1); m_en = 1; step(2); check_state("R4 enabled below");
    set_sys(64'h1_0000_010F); check_state("R2 one short");
    set_sys(64'h1_0000_0110); check_state("R2 equal fires");
    wr(3'd5, 32'h3); m_mask = 1; step(2); check_state("R4 masked");
    wr(3'd5, 32'h1); m_mask = 0; step(2); check_state("R4 unmasked");
    wr(3'd5, 32'h0); m_en = 0; step(2); check_state("R2 disabled status");
    wr(3'd5, 32'h1); m_en = 1; step(2);
    wr(3'd1, 32'h1); m_dl[63:32] = 32'h1; step(2); check_state("R6 high half");
    rd(3'd1, v); check("R6 deadline hi", v, 32'h1);
    wr(3'd1, 32'h0); m_dl[63:32] = 0; step(2); check_state("R6 high cleared");
    set_sys(64'h1_0000_0100); check_state("R4 level falls");
  endtask

  task automatic t_rel;
    logic [31:0] v;
    set_sys(64'h1_0000_0110);
    wr(3'd4, 32'h20); m_dl = 64'h10 + 64'h20;
    rd(3'd0, v); check("R3 rel positive lo", v, m_dl[31:0]);
    rd(3'd1, v); check("R3 rel positive hi", v, m_dl[63:32]);
    rd(3'd4, v); check("R8 remaining positive", v, 32'h20);
    step(1); check_state("R3 rel pending");
    wr(3'd4, 32'hFFFF_FFF0); m_dl = 64'h0;
    step(1); check_state("R3 rel negative met");
    rd(3'd4, v); check("R8 remaining negative", v, 32'hFFFF_FFF0);
    wr(3'd4, 32'hFFFF_FFE0); m_dl = 64'hFFFF_FFFF_FFFF_FFF0;
    rd(3'd1, v); check("R3 sign extend hi", v, 32'hFFFF_FFFF);
    step(1); check_state("R2 unsigned compare");
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(3'd5, 32'hFFFF_FFFC); m_en = 0; m_mask = 0; step(1);
    check_state("R5 junk bits dropped");
    wr(3'd5, 32'h7); m_en = 1; m_mask = 1; step(1);
    check_state("R5 status not writable");
    rd(3'd0, v); check("R5 deadline kept", v, m_dl[31:0]);
    wr(3'd5, 32'h1); m_mask = 0; step(1);
  endtask

  task automatic t_ofs_ignore;
    logic [31:0] v;
    wr(3'd4, 32'h30); m_dl = m_cnt() + 64'h30;
    step(1); check_state("R7 before offset");
    wr(3'd2, 32'h0C0); m_ofs[31:0] = 32'h0C0;
    step(1); check_state("R7 offset reevaluates");
    rd(3'd0, v); check("R7 deadline kept", v, m_dl[31:0]);
    wr(3'd6, 32'h1234); wr(3'd7, 32'h5678); step(1);
    rd(3'd6, v); check("R10 count lo unchanged", v, m_cnt()[31:0]);
    rd(3'd7, v); check("R10 count hi unchanged", v, m_cnt()[63:32]);
    rd(3'd2, v); check("R10 offset unchanged", v, m_ofs[31:0]);
    rd(3'd0, v); check("R10 deadline unchanged", v, m_dl[31:0]);
    check_state("R10 ctrl unchanged");
  endtask

  initial begin
    step(3);
    t_reset;
    t_view;
    t_abs;
    t_rel;
    t_ctrl;
    t_ofs_ignore;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule